// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is the controller-side engine for a serial dataflash on a single-line SPI bus. A client hands it one request at a time over a request/acknowledge interface. The engine turns each request into SPI byte frames. A frame carries an opcode, then an optional 24-bit address, then an optional stream of write bytes or read bytes. Program and erase style commands can ask for a completion wait. The engine then reads the two-byte status word again and again until the device reports ready.

Two requests are built-in sequences. The start-up sequence first wakes the device and waits a programmable exit time. It then reads the three-byte identity and compares it with a configured value. If the identity matches, it reads the status word and switches the device to power-of-two page size, but only when that mode is not already active. The power-down request sends either the normal or the ultra-deep power-down opcode and then waits a programmable enter time. The bit-level shifter runs SPI mode 0, most significant bit first. Its clock is derived from the system clock by a divider parameter.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, busy is 0, id_err is 0 and req_ack is 0 while req_valid is 0.
- R2: A command request (req_kind 2'b00 or 2'b11) sends the opcode byte first. When req_has_addr is 1, it then sends address bits 23:16, 15:8 and 7:0 in that order. Every byte is sent MSB first with mosi changing only while sck is low.
- R3: cs_n stays low for the whole of one frame, including its data phase. It goes high for at least CS_GAP clock cycles between consecutive frames of one request, including before every status poll.
- R4: For a read command (req_write 0), mosi carries 0x00 in each of the req_len data bytes. Each byte received on miso, MSB first, is presented on rd_data with a one-cycle rd_valid pulse, in order.
- R5: For a write command (req_write 1), each of the req_len data bytes is taken from wr_data, with one wr_take pulse for each byte, and sent in order.
- R6: With req_poll 1, a command is followed by status frames. Each frame is opcode 0xD7 followed by two dummy 0x00 bytes, and the first byte returned is the low status byte. Polling repeats until bit 7 of that byte is 1, and busy stays high until that frame ends.
- R7: A start-up request (req_kind 2'b01) sends 0xAB alone. It keeps cs_n high for at least cfg_exit_dly cycles, then sends 0x9F plus three dummy bytes and compares the three returned bytes, first byte against cfg_id[23:16], with cfg_id.
- R8: On an identity mismatch the start-up ends after the 0x9F frame with id_err 1. id_err holds its value while idle and is cleared when the next start-up request is accepted.
- R9: After a matching identity, one status frame is read. If bit 0 of the low status byte is 1, the sequence ends. Otherwise the frame 0x3D 0x2A 0x80 0xA6 is sent, followed by ready polling as in R6.
- R10: A power-down request (req_kind 2'b10) sends the single byte 0xB9, or 0x79 when cfg_ultra is 1. busy then stays high with cs_n high for at least cfg_enter_dly more cycles.
- R11: req_ack is 1 only while the engine is idle and req_valid is 1, and busy rises in the next cycle. A request presented while busy is not acknowledged and produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00/11 command, 01 start-up, 10 power-down |
| req_opcode | input | 8 | Command opcode |
| req_has_addr | input | 1 | Send the 24-bit address after the opcode |
| req_addr | input | 24 | Byte address |
| req_len | input | LEN_W | Number of data bytes |
| req_write | input | 1 | 1 = data bytes are written, 0 = read |
| req_poll | input | 1 | Poll ready after the command |
| req_ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Request in progress |
| wr_data | input | 8 | Next write byte |
| wr_take | output | 1 | wr_data consumed this cycle |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | rd_data valid pulse |
| cfg_id | input | 24 | Expected identity |
| cfg_ultra | input | 1 | Select ultra-deep power-down |
| cfg_exit_dly | input | DLY_W | Wake wait in clock cycles |
| cfg_enter_dly | input | DLY_W | Power-down wait in clock cycles |
| id_err | output | 1 | Identity mismatch seen at last start-up |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |

## Verification
The hardest path to reach is a start-up that takes the conditional page-size branch and then sits in a multi-poll wait. That path needs the device to report the wrong page mode, then report busy for several polls, and then report ready. The bench flash model provides this by starting with the page bit clear and loading a busy count when it sees the configuration frame. A second start-up then finds the bit set and must skip the branch, and a third start-up with a changed model identity drives the mismatch exit. Random commands vary the address, direction, length and per-command busy count, so polling loops of zero to three misses are covered.

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine #(
  parameter int CLK_DIV = 2,
  parameter int LEN_W   = 6,
  parameter int DLY_W   = 16,
  parameter int CS_GAP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [7:0]       req_opcode,
  input  logic             req_has_addr,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  input  logic             req_poll,
  output logic             req_ack,
  output logic             busy,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic [23:0]      cfg_id,
  input  logic             cfg_ultra,
  input  logic [DLY_W-1:0] cfg_exit_dly,
  input  logic [DLY_W-1:0] cfg_enter_dly,
  output logic             id_err,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int IW = LEN_W + 3;
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GW = $clog2(CS_GAP + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_GAP, S_DELAY} state_t;
  typedef enum logic [2:0] {F_CMD, F_STAT, F_ID, F_CFG, F_WAKE, F_PD} frame_t;

  state_t           state;
  frame_t           frame;
  logic [IW-1:0]    idx;
  logic [7:0]       op_q;
  logic             haddr_q, write_q, poll_q, stat_chk, after_dly;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [DLY_W-1:0] dly_cnt;
  logic [GW-1:0]    gap_cnt;
  logic [DW-1:0]    div_cnt;
  logic [2:0]       bit_cnt;
  logic             sck_q, id_err_q, rd_valid_q;
  logic [7:0]       tx_sr, rx_sr, st_lo, rd_q;
  logic [23:0]      id_rx;

  logic [IW-1:0] hdr, last_idx;
  logic          in_data, tick;
  logic [7:0]    tx_byte;

  assign hdr     = haddr_q ? IW'(4) : IW'(1);
  assign in_data = (frame == F_CMD) && (idx >= hdr);
  assign tick    = (div_cnt == DW'(CLK_DIV - 1));

  always_comb begin
    case (frame)
      F_CMD:         last_idx = hdr + IW'(len_q) - IW'(1);
      F_STAT:        last_idx = IW'(2);
      F_ID, F_CFG:   last_idx = IW'(3);
      default:       last_idx = '0;
    endcase
  end

  always_comb begin
    tx_byte = 8'h00;
    case (frame)
      F_CMD: begin
        if (idx == '0)                 tx_byte = op_q;
        else if (in_data)              tx_byte = write_q ? wr_data : 8'h00;
        else if (idx == IW'(1))        tx_byte = addr_q[23:16];
        else if (idx == IW'(2))        tx_byte = addr_q[15:8];
        else                           tx_byte = addr_q[7:0];
      end
      F_STAT: tx_byte = (idx == '0) ? 8'hD7 : 8'h00;
      F_ID:   tx_byte = (idx == '0) ? 8'h9F : 8'h00;
      F_CFG: begin
        case (idx[1:0])
          2'd0:    tx_byte = 8'h3D;
          2'd1:    tx_byte = 8'h2A;
          2'd2:    tx_byte = 8'h80;
          default: tx_byte = 8'hA6;
        endcase
      end
      F_WAKE: tx_byte = 8'hAB;
      F_PD:   tx_byte = cfg_ultra ? 8'h79 : 8'hB9;
      default: tx_byte = 8'h00;
    endcase
  end

  assign req_ack  = (state == S_IDLE) && req_valid;
  assign busy     = (state != S_IDLE);
  assign wr_take  = (state == S_LOAD) && in_data && write_q;
  assign cs_n     = !((state == S_LOAD) || (state == S_SHIFT));
  assign sck      = sck_q;
  assign mosi     = tx_sr[7];
  assign rd_data  = rd_q;
  assign rd_valid = rd_valid_q;
  assign id_err   = id_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      frame      <= F_CMD;
      idx        <= '0;
      op_q       <= '0;
      haddr_q    <= 1'b0;
      write_q    <= 1'b0;
      poll_q     <= 1'b0;
      stat_chk   <= 1'b0;
      after_dly  <= 1'b0;
      addr_q     <= '0;
      len_q      <= '0;
      dly_cnt    <= '0;
      gap_cnt    <= '0;
      div_cnt    <= '0;
      bit_cnt    <= '0;
      sck_q      <= 1'b0;
      id_err_q   <= 1'b0;
      rd_valid_q <= 1'b0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      st_lo      <= '0;
      rd_q       <= '0;
      id_rx      <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q    <= req_opcode;
            haddr_q <= req_has_addr;
            addr_q  <= req_addr;
            len_q   <= req_len;
            write_q <= req_write;
            poll_q  <= req_poll;
            idx     <= '0;
            state   <= S_LOAD;
            case (req_kind)
              2'b01: begin
                frame    <= F_WAKE;
                id_err_q <= 1'b0;
              end
              2'b10:   frame <= F_PD;
              default: frame <= F_CMD;
            endcase
          end
        end
        S_LOAD: begin
          tx_sr   <= tx_byte;
          div_cnt <= '0;
          bit_cnt <= '0;
          sck_q   <= 1'b0;
          state   <= S_SHIFT;
        end
        S_SHIFT: begin
          if (!tick) begin
            div_cnt <= div_cnt + DW'(1);
          end else begin
            div_cnt <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx_sr <= {rx_sr[6:0], miso};
            end else begin
              sck_q <= 1'b0;
              if (bit_cnt != 3'd7) begin
                tx_sr   <= {tx_sr[6:0], 1'b0};
                bit_cnt <= bit_cnt + 3'd1;
              end else begin
                if (frame == F_STAT && idx == IW'(1)) st_lo <= rx_sr;
                if (frame == F_ID && idx != '0)       id_rx <= {id_rx[15:0], rx_sr};
                if (in_data && !write_q) begin
                  rd_q       <= rx_sr;
                  rd_valid_q <= 1'b1;
                end
                if (idx == last_idx) begin
                  gap_cnt <= '0;
                  state   <= S_GAP;
                end else begin
                  idx   <= idx + IW'(1);
                  state <= S_LOAD;
                end
              end
            end
          end
        end
        S_GAP: begin
          if (gap_cnt != GW'(CS_GAP - 1)) begin
            gap_cnt <= gap_cnt + GW'(1);
          end else begin
            idx   <= '0;
            state <= S_LOAD;
            case (frame)
              F_CMD: begin
                frame    <= F_STAT;
                stat_chk <= 1'b0;
                if (!poll_q) state <= S_IDLE;
              end
              F_PD: begin
                dly_cnt   <= cfg_enter_dly;
                after_dly <= 1'b0;
                state     <= S_DELAY;
              end
              F_WAKE: begin
                dly_cnt   <= cfg_exit_dly;
                after_dly <= 1'b1;
                state     <= S_DELAY;
              end
              F_ID: begin
                frame    <= F_STAT;
                stat_chk <= 1'b1;
                if (id_rx != cfg_id) begin
                  id_err_q <= 1'b1;
                  state    <= S_IDLE;
                end
              end
              F_STAT: begin
                if (stat_chk) begin
                  if (st_lo[0]) state <= S_IDLE;
                  else          frame <= F_CFG;
                end else if (st_lo[7]) begin
                  state <= S_IDLE;
                end
              end
              F_CFG: begin
                frame    <= F_STAT;
                stat_chk <= 1'b0;
              end
              default: state <= S_IDLE;
            endcase
          end
        end
        S_DELAY: begin
          if (dly_cnt != '0) begin
            dly_cnt <= dly_cnt - DLY_W'(1);
          end else if (after_dly) begin
            frame <= F_ID;
            idx   <= '0;
            state <= S_LOAD;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sflash_cmd_engine_chk.sv
module sflash_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic req_ack,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic wr_take,
  input logic rd_valid,
  input logic id_err
);
  p_idle_cs_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  p_sck_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  p_ack_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> busy);

  p_ack_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !busy);

  p_take_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !cs_n);

  p_rdv_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(id_err));
endmodule

bind sflash_cmd_engine sflash_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_ack(req_ack), .cs_n(cs_n),
  .sck(sck), .mosi(mosi), .wr_take(wr_take), .rd_valid(rd_valid), .id_err(id_err)
);

// File: tb/sflash_cmd_engine_test.sv
module sflash_cmd_engine_test;
  localparam int LEN_W  = 6;
  localparam int DLY_W  = 16;
  localparam int CS_GAP = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_has_addr = 0, req_write = 0, req_poll = 0;
  logic [1:0] req_kind = 0;
  logic [7:0] req_opcode = 0;
  logic [23:0] req_addr = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic req_ack, busy, wr_take, rd_valid, id_err, sck, cs_n, mosi;
  logic [7:0] wr_data, rd_data;
  logic [23:0] cfg_id = 24'hC1_28_05;
  logic cfg_ultra = 0;
  logic [DLY_W-1:0] cfg_exit_dly = 30, cfg_enter_dly = 40;
  logic miso_r = 0;

  always #2.5 clk = ~clk;

  sflash_cmd_engine #(.CLK_DIV(2), .LEN_W(LEN_W), .DLY_W(DLY_W), .CS_GAP(CS_GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_opcode(req_opcode), .req_has_addr(req_has_addr), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .req_poll(req_poll), .req_ack(req_ack),
    .busy(busy), .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .cfg_id(cfg_id), .cfg_ultra(cfg_ultra),
    .cfg_exit_dly(cfg_exit_dly), .cfg_enter_dly(cfg_enter_dly), .id_err(id_err),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso_r));

  int checks = 0, errs = 0, cmd_id = 0, next_busy = 0;
  logic [23:0] mid = 24'hC1_28_05;
  logic hung = 0;

  // write data source and read data sink (rolling)
  logic [7:0] wd [0:63];
  int wptr = 0, rn = 0;
  logic [7:0] rcv [0:63];
  assign wr_data = wd[wptr % 64];
  always @(posedge clk) begin
    if (wr_take) wptr <= wptr + 1;
    if (rd_valid) begin rcv[rn % 64] <= rd_data; rn <= rn + 1; end
  end

  // flash model / frame monitor, sampling at the falling clock edge
  logic [7:0] fb [0:15][0:39];
  int flen [0:15];
  int gapb [0:15];
  int nfr = 0, gen = -1, bitn = 0, hi_run = 0, model_busy = 0;
  logic page_bit = 0, p_cs = 1, p_sck = 0;
  logic [7:0] sh = 0;

  function automatic logic [7:0] data_pat(int k);
    return 8'(k * 29 + 7) ^ 8'hC3;
  endfunction

  function automatic logic resp_bit(int n);
    int k = n / 8;
    logic [7:0] b, op;
    if (k == 0 || nfr > 15) return 1'b0;
    op = fb[nfr][0];
    if (op == 8'h9F)      b = (k == 1) ? mid[23:16] : (k == 2) ? mid[15:8] : (k == 3) ? mid[7:0] : 8'h00;
    else if (op == 8'hD7) b = (k == 1) ? {model_busy == 0, 6'b0, page_bit} : 8'h5A;
    else                  b = data_pat(k);
    return b[7 - (n % 8)];
  endfunction

  always @(negedge clk) begin
    if (cs_n) begin
      if (!p_cs && nfr < 16) begin
        flen[nfr] = bitn / 8;
        if (fb[nfr][0] == 8'hD7 && model_busy > 0) model_busy = model_busy - 1;
        if (fb[nfr][0] == 8'h3D) begin page_bit = 1; model_busy = 2; end
        nfr = nfr + 1;
        hi_run = 0;
      end
      hi_run = hi_run + 1;
    end else begin
      if (p_cs) begin
        if (gen != cmd_id) begin gen = cmd_id; nfr = 0; model_busy = next_busy; end
        if (nfr < 16) gapb[nfr] = hi_run;
        bitn = 0; miso_r = 0;
      end
      if (sck && !p_sck) begin
        sh = {sh[6:0], mosi};
        bitn = bitn + 1;
        if (bitn % 8 == 0 && nfr < 16 && bitn / 8 <= 40) fb[nfr][bitn/8 - 1] = sh;
      end
      if (!sck && p_sck) miso_r = resp_bit(bitn);
    end
    p_cs = cs_n; p_sck = sck;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp); end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    if (busy) begin hung = 1; chk(0, "R11 watchdog", 1, 0); end
  endtask

  task automatic issue(input logic [1:0] kind, input logic [7:0] op, input logic ha,
                       input logic [23:0] a, input int len, input logic wr, input logic pl);
    @(negedge clk);
    cmd_id++;
    req_kind = kind; req_opcode = op; req_has_addr = ha; req_addr = a;
    req_len = LEN_W'(len); req_write = wr; req_poll = pl; req_valid = 1;
    #1 chk(req_ack === 1'b1, "R11 ack when idle", req_ack, 1);
    @(negedge clk);
    req_valid = 0;
    chk(busy === 1'b1, "R11 busy after ack", busy, 1);
    wait_idle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_bytes(input int fr, input logic [7:0] exp [0:39], input int n, input string tag);
    chk(flen[fr] == n, tag, flen[fr], n);
    for (int i = 0; i < n && i < 40; i++) chk(fb[fr][i] == exp[i], tag, fb[fr][i], exp[i]);
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic ha, input logic [23:0] a,
                         input int len, input logic wr, input int bz, input logic pl);
    logic [7:0] ex [0:39];
    int hd = ha ? 4 : 1, w0 = wptr, r0 = rn;
    for (int j = 0; j < len; j++) wd[(w0 + j) % 64] = 8'($urandom);
    next_busy = bz;
    issue(2'b00, op, ha, a, len, wr, pl);
    ex[0] = op; ex[1] = a[23:16]; ex[2] = a[15:8]; ex[3] = a[7:0];
    for (int j = 0; j < len; j++) ex[hd + j] = wr ? wd[(w0 + j) % 64] : 8'h00;
    chk(nfr == (pl ? bz + 2 : 1), "R6 frame count", nfr, pl ? bz + 2 : 1);
    chk_bytes(0, ex, hd + len, "R2 command frame");
    if (wr) chk(wptr - w0 == len, "R5 wr_take count", wptr - w0, len);
    else begin
      chk(rn - r0 == len, "R4 rd_valid count", rn - r0, len);
      for (int j = 0; j < len; j++)
        chk(rcv[(r0 + j) % 64] == data_pat(hd + j), "R4 read data", rcv[(r0 + j) % 64], data_pat(hd + j));
    end
    ex[0] = 8'hD7; ex[1] = 0; ex[2] = 0;
    for (int f = 1; pl && f < nfr && f < 16; f++) begin
      chk_bytes(f, ex, 3, "R6 status frame");
      chk(gapb[f] >= CS_GAP, "R3 cs gap", gapb[f], CS_GAP);
    end
  endtask

  initial begin
    logic [7:0] ex [0:39];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cs_n === 1 && sck === 0 && busy === 0 && id_err === 0 && req_ack === 0, "R1 reset state",
        {cs_n, sck, busy, id_err, req_ack}, 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // start-up, page size not yet binary: configuration and polling
    next_busy = 0;
    issue(2'b01, 0, 0, 0, 0, 0, 0);
    chk(nfr == 7, "R9 startup frame count with config", nfr, 7);
    ex[0] = 8'hAB; chk_bytes(0, ex, 1, "R7 wake frame");
    chk(gapb[1] >= cfg_exit_dly, "R7 exit delay", gapb[1], cfg_exit_dly);
    ex[0] = 8'h9F; ex[1] = 0; ex[2] = 0; ex[3] = 0; chk_bytes(1, ex, 4, "R7 id frame");
    ex[0] = 8'hD7; chk_bytes(2, ex, 3, "R9 page status frame");
    ex[0] = 8'h3D; ex[1] = 8'h2A; ex[2] = 8'h80; ex[3] = 8'hA6; chk_bytes(3, ex, 4, "R9 config frame");
    ex[0] = 8'hD7; ex[1] = 0; ex[2] = 0;
    for (int f = 4; f < 7; f++) chk_bytes(f, ex, 3, "R6 config poll");
    chk(id_err === 0, "R7 id match", id_err, 0);

    // start-up, page size already binary: no config
    if (!hung) issue(2'b01, 0, 0, 0, 0, 0, 0);
    chk(nfr == 3, "R9 startup skip config", nfr, 3);

    // identity mismatch
    mid = 24'hC1_28_06;
    if (!hung) issue(2'b01, 0, 0, 0, 0, 0, 0);
    chk(nfr == 2, "R8 mismatch stops", nfr, 2);
    chk(id_err === 1, "R8 id_err set", id_err, 1);
    repeat (5) @(negedge clk);
    chk(id_err === 1, "R8 id_err holds", id_err, 1);
    mid = 24'hC1_28_05;
    if (!hung) issue(2'b01, 0, 0, 0, 0, 0, 0);
    chk(id_err === 0, "R8 id_err cleared", id_err, 0);

    // power-down, both variants
    for (int u = 0; u < 2; u++) begin
      cfg_ultra = u[0];
      if (!hung) issue(2'b10, 0, 0, 0, 0, 0, 0);
      ex[0] = u[0] ? 8'h79 : 8'hB9;
      chk_bytes(0, ex, 1, "R10 power-down opcode");
      chk(hi_run >= cfg_enter_dly, "R10 enter delay", hi_run, cfg_enter_dly);
    end

    // requests while busy are ignored
    if (!hung) begin
      @(negedge clk);
      cmd_id++; next_busy = 0;
      req_kind = 2'b00; req_opcode = 8'h0B; req_has_addr = 1; req_addr = 24'h123456;
      req_len = 10; req_write = 0; req_poll = 0; req_valid = 1;
      @(negedge clk);
      req_kind = 2'b10;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        chk(req_ack === 0, "R11 no ack while busy", req_ack, 0);
      end
      req_valid = 0;
      wait_idle();
      repeat (2) @(negedge clk);
      chk(nfr == 1 && flen[0] == 14, "R11 busy request dropped", nfr, 1);
    end

    // directed corners: opcode only, long addressed write with polling
    if (!hung) run_cmd(8'h06, 0, 24'h0, 0, 0, 0, 0);
    if (!hung) run_cmd(8'h82, 1, 24'hFEDCBA, 12, 1, 3, 1);

    // random commands
    for (int i = 0; i < 30 && !hung; i++) begin
      logic [7:0] op = 8'($urandom);
      if (op == 8'h9F || op == 8'hD7 || op == 8'h3D) op = op ^ 8'h01;
      run_cmd(op, 1'($urandom), 24'($urandom), $urandom % 11, 1'($urandom),
              $urandom % 4, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule